// File: doc/BRIEF.md
# Auto-Incrementing Control Register Bank with Atomic Wide Parameter

This block is the register file behind a control port. A byte-level serial bus front end, which is not part of this block, handles pin protocol and device selection. It hands the block one-cycle pulses: a start, a stop, a write strobe with a data byte, and a read request. The first byte written after a start is not stored. It loads an 8-bit subaddress pointer, and that pointer cannot be read back. Each data byte that follows is written to, or read from, the register the pointer selects. The pointer then moves on by one. It wraps from 0xFF to 0x00.

The bank holds 256 plain 8-bit configuration registers, which drive the chip through a flat output. It also holds one 12-bit parameter that spans two neighbouring addresses. The lower address carries the upper bits and is written first. Its byte is held in a shadow register. The 12-bit live output changes all of its bits together, one cycle after the second byte is written. Because of this, downstream logic never sees new upper bits combined with old lower bits.

Top module: `atomic_regbank`

## Requirements
- R1: After reset the pointer is 0x00, every plain register is 0x00, the read data is 0x00, the live wide parameter is 0x35A, and no staged byte is pending.
- R2: The first byte written after a start loads the pointer and changes no register. A read request made before that byte arrives is ignored, and the read data keeps its value.
- R3: Every data byte read or written advances the pointer by one, wrapping from 0xFF to 0x00. Several bytes in one transaction therefore land at consecutive addresses.
- R4: A byte written to a plain register appears on that register's 8-bit slice of the flat output (slice n at bits 8n+7..8n) one cycle after the strobe, and reads back unchanged.
- R5: Address 0x34 holds wide bits [11:8] in its data bits [3:0], and its upper nibble is ignored. Address 0x35 holds wide bits [7:0]. A write to 0x34 only stages a byte and leaves the live value unchanged. The following write to 0x35 updates all 12 live bits in a single cycle.
- R6: A read of 0x34 returns {4'b0000, live[11:8]}, and a read of 0x35 returns live[7:0]. Both reflect the committed value, never a staged byte.
- R7: A register write to any address other than 0x34 or 0x35 discards a pending staged byte. A later write to 0x35 without a fresh staged byte keeps the live upper bits and replaces only the lower eight.
- R8: Write strobes and read requests that come before a start or after a stop change neither the registers, the live value, the pointer, nor the read data.
- R9: Read data is registered. It is valid one cycle after the read request and holds its value until the next read that is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Start of transaction pulse |
| bus_stop | input | 1 | End of transaction pulse |
| bus_wr | input | 1 | Write byte strobe |
| bus_wdata | input | 8 | Byte written |
| bus_rd | input | 1 | Read byte request |
| bus_rdata | output | 8 | Byte read, valid the cycle after the request |
| wide_live | output | 12 | Committed wide parameter |
| cfg_flat | output | 2048 | All plain registers, register n at bits 8n+7..8n |

## Verification
Each bus pulse is sampled on one rising edge. The pointer, the registers, the live wide value and the read data all update on that same edge, so every result is due exactly one cycle after its stimulus. The bench drives each pulse on a falling edge and removes it on the next falling edge. By then the capturing rising edge has passed, so each result is checked at that falling edge, away from any active edge. Hold checks (R5 staging, R8, R9) take their reading after the stimulus and before anything else can change the observed state.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int ADDR_W   = 8;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  active;   // inside a start..stop window
        logic  first;    // next byte loads the pointer
        addr_t ptr;
    } ptr_state_t;
endpackage

// File: rtl/regbank_ptr.sv
module regbank_ptr
    import regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bus_start,
    input  logic  bus_stop,
    input  logic  bus_wr,
    input  byte_t bus_wdata,
    input  logic  bus_rd,
    output addr_t ptr,
    output logic  reg_wr,
    output logic  reg_rd
);
    ptr_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        reg_wr = 1'b0;
        reg_rd = 1'b0;
        if (bus_start) begin
            st_d.active = 1'b1;
            st_d.first  = 1'b1;
        end else if (bus_stop) begin
            st_d.active = 1'b0;
            st_d.first  = 1'b0;
        end else if (st_q.active) begin
            if (st_q.first) begin
                if (bus_wr) begin
                    st_d.ptr   = bus_wdata;
                    st_d.first = 1'b0;
                end
            end else begin
                reg_wr = bus_wr;
                reg_rd = bus_rd;
                if (bus_wr || bus_rd)
                    st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.ptr;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |=> ptr == $past(ptr) + 1'b1); // R3
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.first && bus_wr && !bus_start && !bus_stop)
        |=> ptr == $past(bus_wdata)); // R2
    AST_IDLE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !bus_start) |=> $stable(ptr)); // R8
endmodule

// File: rtl/regbank_wide.sv
module regbank_wide
    import regbank_pkg::*;
#(
    parameter int    WIDE_W       = 12,
    parameter addr_t HI_ADDR      = 8'h34,
    parameter logic [WIDE_W-1:0] WIDE_DEFAULT = 12'h35A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  addr_t             ptr,
    input  byte_t             wdata,
    output logic [WIDE_W-1:0] live
);
    localparam int    HI_W    = WIDE_W - BYTE_W;
    localparam addr_t LO_ADDR = HI_ADDR + 1'b1;

    typedef struct packed {
        logic              staged;
        logic [HI_W-1:0]   shadow;
        logic [WIDE_W-1:0] live;
    } wide_state_t;

    wide_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            if (ptr == HI_ADDR) begin
                st_d.staged = 1'b1;
                st_d.shadow = wdata[HI_W-1:0];
            end else if (ptr == LO_ADDR) begin
                st_d.live   = st_q.staged ? {st_q.shadow, wdata}
                                          : {st_q.live[WIDE_W-1:BYTE_W], wdata};
                st_d.staged = 1'b0;
            end else begin
                st_d.staged = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.live   <= WIDE_DEFAULT;
        end else begin
            st_q <= st_d;
        end
    end

    assign live = st_q.live;

    AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && ptr == HI_ADDR) |=> $stable(live)); // R5
    AST_COMMIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && ptr == LO_ADDR) |=> live[BYTE_W-1:0] == $past(wdata)); // R5
    AST_BREAK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && ptr != HI_ADDR && ptr != LO_ADDR) |=> !st_q.staged); // R7
    AST_LONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && ptr == LO_ADDR && !st_q.staged)
        |=> live[WIDE_W-1:BYTE_W] == $past(live[WIDE_W-1:BYTE_W])); // R7
endmodule

// File: rtl/regbank_store.sv
module regbank_store
    import regbank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  addr_t                    waddr,
    input  byte_t                    wdata,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
    byte_t regs_d [NUM_REGS];
    byte_t regs_q [NUM_REGS];

    always_comb begin
        regs_d = regs_q;
        if (wr_en) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_flat[g*BYTE_W +: BYTE_W] = regs_q[g];
    end

    AST_STORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_flat[$past(waddr)*BYTE_W +: BYTE_W] == $past(wdata)); // R4
endmodule

// File: rtl/atomic_regbank.sv
module atomic_regbank
    import regbank_pkg::*;
#(
    parameter int    WIDE_W       = 12,
    parameter addr_t WIDE_HI_ADDR = 8'h34,
    parameter logic [WIDE_W-1:0] WIDE_DEFAULT = 12'h35A
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_start,
    input  logic                       bus_stop,
    input  logic                       bus_wr,
    input  logic [7:0]                 bus_wdata,
    input  logic                       bus_rd,
    output logic [7:0]                 bus_rdata,
    output logic [WIDE_W-1:0]          wide_live,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_flat
);
    localparam int    HI_W         = WIDE_W - BYTE_W;
    localparam addr_t WIDE_LO_ADDR = WIDE_HI_ADDR + 1'b1;

    addr_t ptr;
    logic  reg_wr, reg_rd, is_wide, plain_wr;
    byte_t rd_d, rd_q;

    regbank_ptr u_ptr (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .ptr(ptr), .reg_wr(reg_wr), .reg_rd(reg_rd)
    );

    regbank_wide #(.WIDE_W(WIDE_W), .HI_ADDR(WIDE_HI_ADDR), .WIDE_DEFAULT(WIDE_DEFAULT)) u_wide (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .ptr(ptr),
        .wdata(bus_wdata), .live(wide_live)
    );

    assign is_wide  = (ptr == WIDE_HI_ADDR) || (ptr == WIDE_LO_ADDR);
    assign plain_wr = reg_wr && !is_wide;

    regbank_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(plain_wr), .waddr(ptr),
        .wdata(bus_wdata), .regs_flat(cfg_flat)
    );

    always_comb begin
        rd_d = rd_q;
        if (reg_rd) begin
            if (ptr == WIDE_HI_ADDR)      rd_d = BYTE_W'(wide_live[WIDE_W-1:BYTE_W]);
            else if (ptr == WIDE_LO_ADDR) rd_d = wide_live[BYTE_W-1:0];
            else                          rd_d = cfg_flat[ptr*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(bus_rdata)); // R9
    AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && ptr == WIDE_HI_ADDR) |=> bus_rdata[BYTE_W-1:HI_W] == '0); // R6
    AST_LO_READ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && ptr == WIDE_LO_ADDR) |=> bus_rdata == $past(wide_live[BYTE_W-1:0])); // R6
endmodule

// File: tb/atomic_regbank_test.sv
module atomic_regbank_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_start = 1'b0, bus_stop = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic [11:0]  wide_live;
    logic [2047:0] cfg_flat;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    atomic_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .wide_live(wide_live), .cfg_flat(cfg_flat)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_at(int a);
        return cfg_flat[a*8 +: 8];
    endfunction

    task automatic do_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
    endtask
    task automatic do_stop();
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
    endtask
    task automatic wr_byte(logic [7:0] d);
        @(negedge clk) begin bus_wr = 1'b1; bus_wdata = d; end
        @(negedge clk) bus_wr = 1'b0;
    endtask
    task automatic rd_byte(output logic [7:0] d);
        @(negedge clk) bus_rd = 1'b1;
        @(negedge clk) begin bus_rd = 1'b0; d = bus_rdata; end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 live default", 32'(wide_live), 32'h35A);
        check("R1 cfg zero", 32'(cfg_flat != '0), 0);
        check("R1 rdata zero", 32'(bus_rdata), 0);
        do_start(); wr_byte(8'h00); rd_byte(d); do_stop();
        check("R1 reg0 read", 32'(d), 0);
    endtask

    task automatic t_pointer();
        logic [7:0] d;
        do_start(); wr_byte(8'h07); wr_byte(8'h5E); do_stop();   // reg7 = 5E
        do_start(); wr_byte(8'h07); rd_byte(d); do_stop();      // rdata = 5E
        do_start();
        rd_byte(d);
        check("R2 read before pointer ignored", 32'(d), 32'h5E);
        wr_byte(8'h09);
        check("R2 pointer byte stores nothing", 32'(reg_at(9)), 0);
        wr_byte(8'h44);
        check("R2 pointer selects target", 32'(reg_at(9)), 32'h44);
        do_stop();
    endtask

    task automatic t_plain_burst();
        logic [7:0] d;
        do_start(); wr_byte(8'h10);
        wr_byte(8'hAA);
        check("R4 output one cycle after strobe", 32'(reg_at(16)), 32'hAA);
        wr_byte(8'hBB); wr_byte(8'hCC); do_stop();
        check("R3 second byte at next address", 32'(reg_at(17)), 32'hBB);
        check("R3 third byte at next address", 32'(reg_at(18)), 32'hCC);
        do_start(); wr_byte(8'h10);
        rd_byte(d); check("R4 readback 0x10", 32'(d), 32'hAA);
        rd_byte(d); check("R3 read increments 0x11", 32'(d), 32'hBB);
        repeat (3) @(negedge clk);
        check("R9 rdata holds while idle", 32'(bus_rdata), 32'hBB);
        rd_byte(d); check("R3 read increments 0x12", 32'(d), 32'hCC);
        do_stop();
    endtask

    task automatic t_wrap();
        do_start(); wr_byte(8'hFF); wr_byte(8'h11); wr_byte(8'h22); do_stop();
        check("R3 write at 0xFF", 32'(reg_at(255)), 32'h11);
        check("R3 wrap to 0x00", 32'(reg_at(0)), 32'h22);
    endtask

    task automatic t_wide_commit();
        logic [7:0] d;
        do_start(); wr_byte(8'h34);
        wr_byte(8'hF7);
        check("R5 staged byte leaves live", 32'(wide_live), 32'h35A);
        wr_byte(8'hC3);
        check("R5 all bits commit together", 32'(wide_live), 32'h7C3);
        do_stop();
        do_start(); wr_byte(8'h34);
        rd_byte(d); check("R6 read 0x34 upper zero", 32'(d), 32'h07);
        rd_byte(d); check("R6 read 0x35 low byte", 32'(d), 32'hC3);
        do_stop();
        do_start(); wr_byte(8'h34); wr_byte(8'h02); do_stop();
        do_start(); wr_byte(8'h34);
        rd_byte(d); check("R6 read is committed not staged", 32'(d), 32'h07);
        do_stop();
        check("R5 stage alone keeps live", 32'(wide_live), 32'h7C3);
    endtask

    task automatic t_break();
        do_start(); wr_byte(8'h34); wr_byte(8'h01); do_stop();
        do_start(); wr_byte(8'h20); wr_byte(8'h55); do_stop();
        check("R7 breaking write stored", 32'(reg_at(32)), 32'h55);
        do_start(); wr_byte(8'h35); wr_byte(8'h99); do_stop();
        check("R7 staged byte discarded", 32'(wide_live), 32'h799);
    endtask

    task automatic t_idle();
        logic [2047:0] snap;
        logic [7:0] d;
        logic [7:0] r0;
        snap = cfg_flat;
        r0 = bus_rdata;
        wr_byte(8'h66);
        rd_byte(d);
        check("R8 idle write ignored", 32'(cfg_flat != snap), 0);
        check("R8 idle read ignored", 32'(d), 32'(r0));
        check("R8 idle live unchanged", 32'(wide_live), 32'h799);
        do_start(); wr_byte(8'h66); do_stop();   // pointer load only
        snap = cfg_flat;
        wr_byte(8'h77);
        check("R8 write after stop ignored", 32'(cfg_flat != snap), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pointer();
        t_plain_burst();
        t_wrap();
        t_wide_commit();
        t_break();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule